// File: doc/BRIEF.md
# Control-Word Register Bus Datapath

This block is the execution core of a small processor. It holds seven general-purpose registers and one shared arithmetic, logic and shift unit. A single packed control word steers it on every clock cycle. Two source selectors each place either one register or the external input word on an operand bus. The unit combines the two buses into a result bus. A destination decoder then writes that result into at most one register on the next rising clock edge.

The result bus always drives the external output port, whether or not a register is written. A microprogram sequencer outside the block supplies one control word per cycle, together with a `valid` qualifier. When `valid` is low, the cycle writes no register. The data width is a parameter, 8 bits by default.

Top module: `rbd_datapath`

## Requirements
- R1: The 14-bit control word is split, from bit 13 down to bit 0, into the A-source code [13:11], the B-source code [10:8], the destination code [7:5] and the operation code [4:0]. For example, 14'b010_011_001_00101 writes register 2 minus register 3 into register 1.
- R2: A source code from 1 to 7 puts register 1 to 7 on that operand bus. Source code 0 puts `ext_in` on that bus.
- R3: When `valid` is high, destination code k (1 to 7) loads the result into register k on the next rising clock edge. Every other register keeps its value.
- R4: Destination code 0 loads no register. `ext_out` still shows the result within the same cycle.
- R5: When `valid` is low, no register is loaded, whatever the destination code holds.
- R6: The arithmetic codes are 00001 for A+1, 00010 for A+B, 00101 for A−B and 00110 for A−1. All of them wrap modulo 2^width.
- R7: The transfer and logic codes are 00000 for A, 01000 for A AND B, 01010 for A OR B, 01100 for A XOR B and 01110 for NOT A. The increment, decrement, transfer, complement and shift codes ignore bus B.
- R8: Code 10000 shifts A right by one bit and fills the top bit with 0. Code 11000 shifts A left by one bit and fills bit 0 with 0.
- R9: Any other operation code drives zero on the result bus.
- R10: Driving `rst_n` low clears all seven registers at once. Its release takes effect two clock edges later. An all-zero control word copies `ext_in` to `ext_out` and writes no register.
- R11: XOR of a register with itself, with that register as destination, clears the register to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| valid | input | 1 | Qualifies the register load of this cycle |
| ctrl_word | input | 14 | A-source, B-source, destination and operation fields |
| ext_in | input | W | External data word, selected by source code 0 |
| ext_out | output | W | Result bus, driven every cycle |

## Verification
Seeded random control words cover every pairing of source codes, destination codes and `valid`. Because later words read registers back through the transfer code, a write to the wrong register, a missed write or a write while `valid` is low shows up as a wrong value. Random operands exercise each operation code, and values near 0 and all-ones separate wrap-around, shift fill and unused-code results. Directed words cover the subtract example, the all-zero pass-through, clearing a register with XOR, and a reset asserted in the middle of the run.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

  localparam int SEL_W = 3;
  localparam int OP_W  = 5;
  localparam int CW_W  = 3 * SEL_W + OP_W;

  typedef enum logic [OP_W-1:0] {
    OP_TSFA = 5'b00000,
    OP_INCA = 5'b00001,
    OP_ADD  = 5'b00010,
    OP_SUB  = 5'b00101,
    OP_DECA = 5'b00110,
    OP_AND  = 5'b01000,
    OP_OR   = 5'b01010,
    OP_XOR  = 5'b01100,
    OP_COMA = 5'b01110,
    OP_SHRA = 5'b10000,
    OP_SHLA = 5'b11000
  } alu_op_e;

  typedef struct packed {
    logic [SEL_W-1:0] src_a;
    logic [SEL_W-1:0] src_b;
    logic [SEL_W-1:0] dst;
    logic [OP_W-1:0]  op;
  } ctrl_word_t;

  function automatic logic op_is_legal(input logic [OP_W-1:0] op);
    case (op)
      OP_TSFA, OP_INCA, OP_ADD, OP_SUB, OP_DECA, OP_AND,
      OP_OR, OP_XOR, OP_COMA, OP_SHRA, OP_SHLA: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rbd_rst_sync.sv
module rbd_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      srst_n  <= stage_q;
    end
  end

endmodule

// File: rtl/rbd_regfile.sv
module rbd_regfile #(
  parameter int W    = 8,
  parameter int NREG = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NREG-1:0]           we,
  input  logic [W-1:0]              wdata,
  output logic [NREG-1:0][W-1:0]    q
);

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [W-1:0] d;

    always_comb begin
      d = q[k];
      if (we[k]) d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[k] <= '0;
      else if (we[k]) q[k] <= d;
    end

    // R3: an enabled register captures the result bus
    a_r3_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
      we[k] |=> q[k] == $past(wdata));

    // R3: a register that is not enabled keeps its value
    a_r3_hold_unselected: assert property (@(posedge clk) disable iff (!rst_n)
      !we[k] |=> $stable(q[k]));
  end

endmodule

// File: rtl/rbd_opmux.sv
module rbd_opmux #(
  parameter int W     = 8,
  parameter int NREG  = 7,
  parameter int SEL_W = 3
) (
  input  logic [SEL_W-1:0]          sel,
  input  logic [W-1:0]              ext,
  input  logic [NREG-1:0][W-1:0]    regs,
  output logic [W-1:0]              bus
);

  always_comb begin
    bus = ext;
    for (int k = 0; k < NREG; k++) begin
      if (sel == SEL_W'(k + 1)) bus = regs[k];
    end
  end

endmodule

// File: rtl/rbd_alu.sv
module rbd_alu
  import rbd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    y
);

  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    case (op)
      OP_TSFA: y = a;
      OP_INCA: y = a + ONE;
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_DECA: y = a - ONE;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_COMA: y = ~a;
      OP_SHRA: y = {1'b0, a[W-1:1]};
      OP_SHLA: y = {a[W-2:0], 1'b0};
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/rbd_datapath.sv
module rbd_datapath
  import rbd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic [13:0]     ctrl_word,
  input  logic [W-1:0]    ext_in,
  output logic [W-1:0]    ext_out
);

  localparam int NREG = (1 << SEL_W) - 1;

  ctrl_word_t               cw;
  logic                     srst_n;
  logic [NREG-1:0][W-1:0]   regs;
  logic [W-1:0]             bus_a;
  logic [W-1:0]             bus_b;
  logic [W-1:0]             result;
  logic [NREG-1:0]          we;

  assign cw = ctrl_word_t'(ctrl_word);

  rbd_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  rbd_opmux #(.W(W), .NREG(NREG), .SEL_W(SEL_W)) u_mux_a (
    .sel (cw.src_a), .ext (ext_in), .regs (regs), .bus (bus_a)
  );

  rbd_opmux #(.W(W), .NREG(NREG), .SEL_W(SEL_W)) u_mux_b (
    .sel (cw.src_b), .ext (ext_in), .regs (regs), .bus (bus_b)
  );

  rbd_alu #(.W(W)) u_alu (
    .op (cw.op), .a (bus_a), .b (bus_b), .y (result)
  );

  for (genvar k = 0; k < NREG; k++) begin : g_dec
    assign we[k] = valid && (cw.dst == SEL_W'(k + 1));
  end

  rbd_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk   (clk),
    .rst_n (srst_n),
    .we    (we),
    .wdata (result),
    .q     (regs)
  );

  assign ext_out = result;

  // R5: no load enable while valid is low
  a_r5_no_load_invalid: assert property (@(posedge clk) disable iff (!srst_n)
    !valid |-> we == '0);

  // R4: at most one destination is enabled
  a_r4_dec_onehot: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(we));

  // R4: destination code 0 leaves every register unchanged
  a_r4_no_dest_hold: assert property (@(posedge clk) disable iff (!srst_n)
    cw.dst == '0 |=> $stable(regs));

  // R2: source code 0 selects the external word
  a_r2_ext_on_a: assert property (@(posedge clk) disable iff (!srst_n)
    cw.src_a == '0 |-> bus_a == ext_in);

  // R6: subtraction seen at the output port
  a_r6_sub_out: assert property (@(posedge clk) disable iff (!srst_n)
    cw.op == OP_SUB |-> ext_out == W'(bus_a - bus_b));

  // R9: unused operation codes give zero
  a_r9_unused_zero: assert property (@(posedge clk) disable iff (!srst_n)
    !op_is_legal(cw.op) |-> ext_out == '0);

endmodule

// File: tb/rbd_datapath_tb_top.sv
`timescale 1ns/1ps
module rbd_datapath_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         valid;
  logic [13:0]  ctrl_word;
  logic [W-1:0] ext_in;
  logic [W-1:0] ext_out;

  int vectors = 0;
  int fails   = 0;
  logic [W-1:0] mdl [1:7];

  always #2.5 clk = ~clk;

  rbd_datapath #(.W(W)) dut_i (
    .clk (clk), .rst_n (rst_n), .valid (valid),
    .ctrl_word (ctrl_word), .ext_in (ext_in), .ext_out (ext_out)
  );

  function automatic logic [W-1:0] ref_alu(input logic [4:0] op,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] b);
    case (op)
      5'b00000: return a;
      5'b00001: return W'(a + 1);
      5'b00010: return W'(a + b);
      5'b00101: return W'(a - b);
      5'b00110: return W'(a - 1);
      5'b01000: return a & b;
      5'b01010: return a | b;
      5'b01100: return a ^ b;
      5'b01110: return ~a;
      5'b10000: return a >> 1;
      5'b11000: return a << 1;
      default:  return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] op);
    case (op)
      5'b00001, 5'b00010, 5'b00101, 5'b00110: return "R6";
      5'b00000, 5'b01000, 5'b01010, 5'b01100, 5'b01110: return "R7";
      5'b10000, 5'b11000: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [W-1:0] src_val(input logic [2:0] s, input logic [W-1:0] x);
    return (s == 3'd0) ? x : mdl[s];
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: ext_out=%02h expected=%02h", tag, got, exp);
    end
  endtask

  // drive at negedge, check mid-cycle, update model at posedge
  task automatic apply(input logic [2:0] sa, input logic [2:0] sb, input logic [2:0] sd,
                       input logic [4:0] op, input logic [W-1:0] din, input logic v,
                       input string tag);
    logic [W-1:0] exp;
    @(negedge clk);
    ctrl_word = {sa, sb, sd, op};
    ext_in    = din;
    valid     = v;
    exp = ref_alu(op, src_val(sa, din), src_val(sb, din));
    #1;
    check(tag, ext_out, exp);
    @(posedge clk);
    if (v && sd != 3'd0) mdl[sd] = exp;
  endtask

  task automatic read_all(input string tag);
    for (int k = 1; k <= 7; k++) apply(3'(k), 3'd0, 3'd0, 5'b00000, 8'h5A, 1'b1, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    #1 rst_n = 1'b0;
    for (int k = 1; k <= 7; k++) mdl[k] = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: ended=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [4:0] ops [11];
    ops = '{5'b00000, 5'b00001, 5'b00010, 5'b00101, 5'b00110, 5'b01000,
            5'b01010, 5'b01100, 5'b01110, 5'b10000, 5'b11000};
    void'($urandom(32'd20240611));
    rst_n = 1'b0; valid = 1'b0; ctrl_word = '0; ext_in = '0;
    for (int k = 1; k <= 7; k++) mdl[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R10: registers read zero after reset
    read_all("R10");

    // R10: all-zero word passes ext_in through, no write
    apply(3'd0, 3'd0, 3'd0, 5'b00000, 8'hC3, 1'b1, "R10");
    read_all("R4");

    // R2/R3: load R2, R3 from ext_in
    apply(3'd0, 3'd0, 3'd2, 5'b00000, 8'h40, 1'b1, "R2");
    apply(3'd0, 3'd0, 3'd3, 5'b00000, 8'h55, 1'b1, "R3");
    // R1: word 010 011 001 00101 -> R1 = R2 - R3 (wraps)
    apply(3'd2, 3'd3, 3'd1, 5'b00101, 8'h00, 1'b1, "R1");
    apply(3'd1, 3'd0, 3'd0, 5'b00000, 8'h00, 1'b1, "R1");
    // R5: valid low writes nothing
    apply(3'd0, 3'd0, 3'd1, 5'b00000, 8'hEE, 1'b0, "R5");
    apply(3'd1, 3'd0, 3'd0, 5'b00000, 8'h00, 1'b1, "R5");
    // R8: shift fills with 0
    apply(3'd0, 3'd0, 3'd4, 5'b10000, 8'hFF, 1'b1, "R8");
    apply(3'd0, 3'd0, 3'd5, 5'b11000, 8'hFF, 1'b1, "R8");
    // R6: wrap at all-ones and zero
    apply(3'd0, 3'd0, 3'd6, 5'b00001, 8'hFF, 1'b1, "R6");
    apply(3'd0, 3'd0, 3'd7, 5'b00110, 8'h00, 1'b1, "R6");
    // R9: unused code gives zero
    apply(3'd0, 3'd0, 3'd0, 5'b11111, 8'hA5, 1'b1, "R9");
    // R11: XOR with itself clears
    apply(3'd3, 3'd3, 3'd3, 5'b01100, 8'h00, 1'b1, "R11");
    read_all("R11");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] op;
      op = ($urandom % 8 == 0) ? 5'($urandom) : ops[$urandom % 11];
      apply(3'($urandom), 3'($urandom), 3'($urandom), op, W'($urandom),
            ($urandom % 8) != 0, tag_of(op));
      if (i % 500 == 499) read_all("R3");
    end

    // R10: asynchronous reset mid-run
    do_reset();
    read_all("R10");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule